// File: doc/BRIEF.md
# Banked Memory Mapper

This block sits between a CPU with a 16-bit address bus and a physical memory of up to 1 MB. The CPU space is cut into four 16 KB windows. Each window has its own page register, and that register supplies the upper bits of the physical address. The low 14 address bits are passed through as the offset inside the page. The top 8 KB of the CPU space always reaches the boot ROM, whatever its page register holds. Reset vectors and monitor code can therefore be fetched before software has set up any mapping.

Software reaches the page registers through a dedicated chip-select. The two low address bits pick one of the four registers. A write cycle loads that register, and a read cycle returns its contents on the data bus. This lets an operating system recover the current mapping at any time. The width of the registers is set by a parameter:

- **Narrow variant:** 4-bit pages, which address 256 KB from one RAM bank.
- **Wide variant:** 8-bit pages. Page bits [5:0] form the upper physical address, and page bit 5 chooses between two 512 KB RAM banks, for a total of 1 MB.

The bus is a plain single-cycle interface with no valid/ready handshake and no back-pressure. Every cycle is a complete transfer. The address outputs and select outputs follow the inputs combinationally. The page registers update only on the clock edge that ends a write cycle.

Top module: `bank_mapper`

## Requirements
- R1: After reset, page register k (k = 0..3) holds the value k, so the first 64 KB is identity-mapped; reading register k returns k.
- R2: For an access outside the ROM region, CPU address bits [15:14] select the page register whose value forms the upper physical address: wide variant phys = {page[5:0], addr[13:0]}, narrow variant phys = {2'b00, page[3:0], addr[13:0]}.
- R3: Physical address bits [13:0] equal CPU address bits [13:0] for every RAM access.
- R4: A cycle with map_cs=1 and cpu_rw=0 loads the register indexed by cpu_addr[1:0] with cpu_wdata (low 4 bits in the narrow variant); the other three registers keep their values.
- R5: A cycle with map_cs=1 and cpu_rw=1 drives the register indexed by cpu_addr[1:0] onto cpu_rdata, zero-extended to 8 bits in the narrow variant; in every other cycle cpu_rdata is 0.
- R6: A page write changes the translation only from the next cycle; during the write cycle itself phys_addr still uses the old page value.
- R7: When CPU address bits [15:13] are all 1, rom_sel=1, ram_sel=0 and phys_addr = {7'b0, addr[12:0]}, regardless of the window-3 page register.
- R8: ram_sel is one-hot or zero: 2'b01 selects RAM bank 0 and 2'b10 selects bank 1. In the wide variant page bit 5 chooses the bank and page bits [7:6] have no effect. The narrow variant always selects bank 0.
- R9: While map_cs=1, both rom_sel and ram_sel are 0, while phys_addr still shows the translation of cpu_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| map_cs | input | 1 | Page register select (I/O cycle) |
| phys_addr | output | 20 | Translated physical address |
| ram_sel | output | 2 | One-hot RAM bank select |
| rom_sel | output | 1 | Boot ROM select |
| cpu_rdata | output | 8 | Page register readback |

## Verification
The following outputs are combinational in the inputs of the current cycle and are due in that same cycle:

- phys_addr
- ram_sel
- rom_sel
- cpu_rdata

A page write becomes visible only one clock edge later. The bench drives each bus cycle just after a falling edge, then samples all outputs a little later in the same low phase. This keeps every sample clear of the rising edge that commits a write. The expected values come from a bench-side page model, and that model is updated only after the write cycle's expectation has been queued. As a result, the write cycle is checked against the old page and the following cycle against the new one. A wide and a narrow instance run side by side on the same stimulus.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  // RAM bank one-hot encodings
  localparam logic [1:0] BANK_NONE = 2'b00;
  localparam logic [1:0] BANK_LO   = 2'b01;
  localparam logic [1:0] BANK_HI   = 2'b10;

  typedef struct packed {
    logic       rom;
    logic [1:0] ram;
  } mem_sel_t;
endpackage

// File: rtl/bmu_page_regs.sv
module bmu_page_regs #(
  parameter int NUM_WIN = 4,
  parameter int PAGE_W  = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [PAGE_W-1:0]              wr_data,
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic [IDX_W-1:0]               win_idx,
  output logic [PAGE_W-1:0]              rd_page,
  output logic [PAGE_W-1:0]              win_page
);
  logic [NUM_WIN-1:0][PAGE_W-1:0] page_q;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        page_q[i] <= PAGE_W'(i);   // identity mapping at reset
      else if (wr_en && wr_idx == IDX_W'(i))
        page_q[i] <= wr_data;
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> page_q[i] == $past(wr_data));
    assert_others_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(page_q[i]));
  end

  assign rd_page  = page_q[rd_idx];
  assign win_page = page_q[win_idx];
endmodule

// File: rtl/bmu_xlate.sv
module bmu_xlate
  import bank_mapper_pkg::*;
#(
  parameter int  CPU_AW = 16,
  parameter int  OFF_W  = 14,
  parameter int  PAGE_W = 8,
  parameter int  PA_W   = 20,
  parameter int  ROM_AW = 13,
  parameter bit  WIDE   = 1'b1
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [PAGE_W-1:0] page,
  input  logic              io_cycle,
  output logic [PA_W-1:0]   phys_addr,
  output mem_sel_t          sel
);
  localparam int UPPER_W = PA_W - OFF_W;   // page bits that reach the bus

  logic                rom_hit;
  logic [PA_W-1:0]     ram_addr;
  logic [1:0]          bank;

  assign rom_hit = &cpu_addr[CPU_AW-1:ROM_AW];

  if (WIDE) begin : g_wide
    logic unused_page_hi;
    assign unused_page_hi = ^page[PAGE_W-1:UPPER_W];
    assign ram_addr = {page[UPPER_W-1:0], cpu_addr[OFF_W-1:0]};
    assign bank     = page[UPPER_W-1] ? BANK_HI : BANK_LO;
  end else begin : g_narrow
    localparam int PAD_W = PA_W - OFF_W - PAGE_W;
    assign ram_addr = {{PAD_W{1'b0}}, page, cpu_addr[OFF_W-1:0]};
    assign bank     = BANK_LO;
  end

  always_comb begin
    if (rom_hit) begin
      phys_addr = {{(PA_W-ROM_AW){1'b0}}, cpu_addr[ROM_AW-1:0]};
      sel.rom   = !io_cycle;
      sel.ram   = BANK_NONE;
    end else begin
      phys_addr = ram_addr;
      sel.rom   = 1'b0;
      sel.ram   = io_cycle ? BANK_NONE : bank;
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter bit WIDE_PAGES = 1'b1,
  parameter int NUM_WIN    = 4,
  parameter int CPU_AW     = 16,
  parameter int DATA_W     = 8,
  parameter int PA_W       = 20,
  parameter int ROM_AW     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rw,
  input  logic              map_cs,
  output logic [PA_W-1:0]   phys_addr,
  output logic [1:0]        ram_sel,
  output logic              rom_sel,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int WIN_W  = $clog2(NUM_WIN);
  localparam int OFF_W  = CPU_AW - WIN_W;
  localparam int PAGE_W = WIDE_PAGES ? DATA_W : DATA_W / 2;

  logic [PAGE_W-1:0] rd_page;
  logic [PAGE_W-1:0] win_page;
  logic              wr_en;
  mem_sel_t          sel;
  logic              unused_wdata;

  assign wr_en        = map_cs && !cpu_rw;
  assign unused_wdata = ^cpu_wdata;

  bmu_page_regs #(
    .NUM_WIN (NUM_WIN),
    .PAGE_W  (PAGE_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (cpu_addr[WIN_W-1:0]),
    .wr_data  (cpu_wdata[PAGE_W-1:0]),
    .rd_idx   (cpu_addr[WIN_W-1:0]),
    .win_idx  (cpu_addr[CPU_AW-1:OFF_W]),
    .rd_page  (rd_page),
    .win_page (win_page)
  );

  bmu_xlate #(
    .CPU_AW (CPU_AW),
    .OFF_W  (OFF_W),
    .PAGE_W (PAGE_W),
    .PA_W   (PA_W),
    .ROM_AW (ROM_AW),
    .WIDE   (WIDE_PAGES)
  ) u_xlate (
    .cpu_addr  (cpu_addr),
    .page      (win_page),
    .io_cycle  (map_cs),
    .phys_addr (phys_addr),
    .sel       (sel)
  );

  assign ram_sel   = sel.ram;
  assign rom_sel   = sel.rom;
  assign cpu_rdata = (map_cs && cpu_rw) ? DATA_W'(rd_page) : '0;

  assert_bank_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_sel));
  assert_rom_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (ram_sel == 2'b00));
  assert_io_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_cs |-> (!rom_sel && ram_sel == 2'b00));
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel != 2'b00) |-> (phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));
  assert_rdata_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_cs && cpu_rw) |-> (cpu_rdata == '0));
  assert_rom_vectors_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&cpu_addr[CPU_AW-1:ROM_AW] && !map_cs) |-> rom_sel);
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rw = 1'b1;
  logic        map_cs = 1'b0;

  logic [19:0] w_phys, n_phys;
  logic [1:0]  w_ram, n_ram;
  logic        w_rom, n_rom;
  logic [7:0]  w_rd, n_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper #(.WIDE_PAGES(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rw(cpu_rw), .map_cs(map_cs), .phys_addr(w_phys), .ram_sel(w_ram),
    .rom_sel(w_rom), .cpu_rdata(w_rd));

  bank_mapper #(.WIDE_PAGES(1'b0)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rw(cpu_rw), .map_cs(map_cs), .phys_addr(n_phys), .ram_sel(n_ram),
    .rom_sel(n_rom), .cpu_rdata(n_rd));

  typedef struct {
    logic [19:0] w_phys; logic [1:0] w_ram; logic w_rom; logic [7:0] w_rd;
    logic [19:0] n_phys; logic [1:0] n_ram; logic n_rom; logic [7:0] n_rd;
    string tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] wm [4];
  logic [3:0] nm [4];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one bus cycle, expectation taken from the page model before a write lands
  task automatic bus(logic [15:0] a, logic rw, logic cs, logic [7:0] d, string tag);
    exp_t e;
    logic [7:0] wp;
    logic [3:0] np;
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; map_cs = cs; cpu_wdata = d;
    wp = wm[a[15:14]];
    np = nm[a[15:14]];
    if (a[15:13] == 3'b111) begin
      e.w_phys = {7'b0, a[12:0]}; e.w_ram = 2'b00; e.w_rom = !cs;
      e.n_phys = {7'b0, a[12:0]}; e.n_ram = 2'b00; e.n_rom = !cs;
    end else begin
      e.w_phys = {wp[5:0], a[13:0]};
      e.w_ram  = cs ? 2'b00 : (wp[5] ? 2'b10 : 2'b01);
      e.w_rom  = 1'b0;
      e.n_phys = {2'b00, np, a[13:0]};
      e.n_ram  = cs ? 2'b00 : 2'b01;
      e.n_rom  = 1'b0;
    end
    e.w_rd = (cs && rw) ? wm[a[1:0]] : 8'h00;
    e.n_rd = (cs && rw) ? {4'h0, nm[a[1:0]]} : 8'h00;
    e.tag  = tag;
    sb_q.push_back(e);
    if (cs && !rw) begin
      wm[a[1:0]] = d;
      nm[a[1:0]] = d[3:0];
    end
  endtask

  // monitor: samples in the low phase, away from the committing edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check("wide phys", e.tag, 32'(w_phys), 32'(e.w_phys));
        check("wide ram",  e.tag, 32'(w_ram),  32'(e.w_ram));
        check("wide rom",  e.tag, 32'(w_rom),  32'(e.w_rom));
        check("wide rd",   e.tag, 32'(w_rd),   32'(e.w_rd));
        check("narrow phys", e.tag, 32'(n_phys), 32'(e.n_phys));
        check("narrow ram",  e.tag, 32'(n_ram),  32'(e.n_ram));
        check("narrow rom",  e.tag, 32'(n_rom),  32'(e.n_rom));
        check("narrow rd",   e.tag, 32'(n_rd),   32'(e.n_rd));
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      wm[k] = 8'(k);
      nm[k] = 4'(k);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R5: reset identity readback, zero-extended in narrow variant
    for (int k = 0; k < 4; k++) bus(16'(k), 1'b1, 1'b1, 8'h00, "R1_R5");
    // R2 / R3: identity-mapped accesses in windows 0..2
    bus(16'h1234, 1'b1, 1'b0, 8'h00, "R2_R3");
    bus(16'h5678, 1'b0, 1'b0, 8'h77, "R2_R3");
    bus(16'h9ABC, 1'b1, 1'b0, 8'h00, "R2_R3");
    // R6 / R9: write window 1 page; same cycle shows old translation, no selects
    bus(16'h4001, 1'b0, 1'b1, 8'h2A, "R6_R9");
    bus(16'h4123, 1'b1, 1'b0, 8'h00, "R6_R8");
    // R8: upper page bits ignored, bank 1 via bit 5
    bus(16'h0002, 1'b0, 1'b1, 8'hFF, "R4");
    bus(16'h8000, 1'b1, 1'b0, 8'h00, "R8");
    bus(16'hBFFF, 1'b0, 1'b0, 8'h00, "R8");
    // R4: index comes from low bits, window field differs
    bus(16'h0003, 1'b0, 1'b1, 8'h05, "R4");
    bus(16'hC000, 1'b1, 1'b0, 8'h00, "R4_R2");
    bus(16'hDFFF, 1'b1, 1'b0, 8'h00, "R4_R2");
    // R7: ROM region ignores window 3 page
    bus(16'hE010, 1'b1, 1'b0, 8'h00, "R7");
    bus(16'hFFFE, 1'b1, 1'b0, 8'h00, "R7");
    bus(16'hE003, 1'b1, 1'b1, 8'h00, "R7_R9_R5");
    // R4: window 0 to bank 0 with a high page, others unchanged
    bus(16'h0000, 1'b0, 1'b1, 8'h10, "R4");
    bus(16'h0FFF, 1'b1, 1'b0, 8'h00, "R4_R8");
    for (int k = 0; k < 4; k++) bus(16'(k), 1'b1, 1'b1, 8'h00, "R4_R5");
    bus(16'h2000, 1'b1, 1'b0, 8'h00, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule